// File: doc/BRIEF.md
# FIFO Ticket Lock Arbiter

A single hardware lock shared by a fixed set of requesters that hands out ownership strictly in arrival order. The lock keeps two counters: a dispenser that gives out tickets and a serving counter that names the ticket which currently owns the lock. Any number of requesters may ask in the same cycle. Each one gets a distinct ticket, and the dispenser moves forward by the number of tickets it handed out, so no two requesters ever hold the same ticket.

A requester pulses its acquire line once, then waits until its granted flag rises. It holds the lock until it pulses its release line. The release advances the serving counter by one, and the lock passes to the holder of the next ticket. A release from a requester that does not own the lock changes nothing, and it raises a one-cycle error flag.

Top module: `ticket_lock_unit`

## Requirements
- R1: While reset is high and in the cycle after it falls, every granted flag is 0, every ticket output is 0 and the error flag is 0. Both internal counters start at 0.
- R2: An acquire pulse from an idle requester gives that requester the current dispenser value. The value appears on the requester's ticket field, bits [i*W +: W], on the cycle after the pulse. The dispenser then advances by one.
- R3: When several idle requesters pulse acquire in the same cycle, they receive consecutive tickets in ascending index order. The lowest index gets the lowest ticket.
- R4: A requester's granted flag is 1 exactly when it is waiting or holding and its ticket equals the serving counter. At most one granted flag is 1 at any time, and a grant persists until its owner releases.
- R5: A release pulse from the owner advances the serving counter by one. It clears the owner's grant on the next cycle, and on that same cycle the holder of the next ticket, if any, becomes granted.
- R6: A release pulse from a requester that is not granted leaves every counter and grant unchanged. It sets rel_err_o to 1 on the next cycle only.
- R7: An acquire pulse from a requester that is already waiting or holding is ignored. Its ticket and the dispenser are unchanged.
- R8: Both counters are W = log2(N_REQ)+1 bits wide and wrap modulo 2^W. Grants continue in strict issue order across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_i | input | N_REQ | Per-requester acquire pulse |
| rel_i | input | N_REQ | Per-requester release pulse |
| ticket_o | output | N_REQ*W | Ticket held by each requester, field i at bits [i*W +: W] |
| granted_o | output | N_REQ | Per-requester ownership flag |
| rel_err_o | output | 1 | One-cycle flag for a release by a non-owner |

## Verification
The bench targets several corner cases.

- **Simultaneous acquires.** Three requesters ask in the same cycle. A design that counted only one ticket per cycle, or that ordered the requesters wrongly, would give out duplicate or swapped tickets, and two requesters would then own the lock at once or be served out of order.
- **Release and acquire in one cycle by the owner.** A design that re-queued the owner here would hand it a fresh ticket it never asked for.
- **A repeated acquire from a waiting requester.** A design that did not ignore it would overwrite the ticket and strand the queue.
- **A stray release.** A design that did not ignore it would advance the serving counter and skip a waiter.
- **Long random runs.** These drive both counters through many wraps. A design that compared tickets with the wrong width, or that lost a carry, would stall or grant out of order after the first wrap.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  function automatic int unsigned tlk_cnt_width(input int unsigned n_req);
    return $clog2(n_req) + 1;
  endfunction
endpackage

// File: rtl/tlk_dispenser.sv
module tlk_dispenser #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned W     = 3
) (
  input  logic [W-1:0]       base_i,
  input  logic [N_REQ-1:0]   take_i,
  output logic [N_REQ*W-1:0] tk_for_o,
  output logic [W-1:0]       next_o
);
  // Prefix count: requester i gets base plus number of lower-index takers.
  logic [W-1:0] run [N_REQ+1];

  assign run[0] = base_i;

  genvar gi;
  generate
    for (gi = 0; gi < N_REQ; gi++) begin : g_pre
      assign tk_for_o[gi*W +: W] = run[gi];
      assign run[gi+1] = take_i[gi] ? run[gi] + W'(1) : run[gi];
    end
  endgenerate

  assign next_o = run[N_REQ];
endmodule

// File: rtl/tlk_slot.sv
module tlk_slot #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_i,
  input  logic [W-1:0] new_tk_i,
  input  logic         rel_i,
  input  logic [W-1:0] serve_nxt_i,
  output logic         active_o,
  output logic [W-1:0] ticket_o,
  output logic         owner_o,
  output logic         rel_ok_o,
  output logic         rel_bad_o
);
  logic         act_q, act_n;
  logic [W-1:0] tk_q, tk_n;
  logic         own_q, own_n;

  assign rel_ok_o  = rel_i & own_q;
  assign rel_bad_o = rel_i & ~own_q;

  always_comb begin
    act_n = act_q;
    tk_n  = tk_q;
    if (take_i) begin
      act_n = 1'b1;
      tk_n  = new_tk_i;
    end else if (rel_ok_o) begin
      act_n = 1'b0;
    end
    own_n = act_n && (tk_n == serve_nxt_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      tk_q  <= '0;
      own_q <= 1'b0;
    end else begin
      act_q <= act_n;
      tk_q  <= tk_n;
      own_q <= own_n;
    end
  end

  assign active_o = act_q;
  assign ticket_o = tk_q;
  assign owner_o  = own_q;

  // Ownership is kept until the owner releases.
  assert_grant_held_R4: assert property (@(posedge clk) disable iff (rst)
    own_q && !rel_i |=> own_q);
  // An accepted release drops the grant on the next cycle.
  assert_release_drops_R5: assert property (@(posedge clk) disable iff (rst)
    rel_ok_o |=> !own_q);
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int unsigned N_REQ = 4,
  localparam int unsigned W    = tlk_pkg::tlk_cnt_width(N_REQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_REQ-1:0]   acq_i,
  input  logic [N_REQ-1:0]   rel_i,
  output logic [N_REQ*W-1:0] ticket_o,
  output logic [N_REQ-1:0]   granted_o,
  output logic               rel_err_o
);
  logic [W-1:0]       disp_q, disp_n;
  logic [W-1:0]       serve_q, serve_n;
  logic               err_q;
  logic [N_REQ-1:0]   active, take, owner, rel_ok, rel_bad;
  logic [N_REQ*W-1:0] tk_for;

  assign take = acq_i & ~active;

  tlk_dispenser #(.N_REQ(N_REQ), .W(W)) u_disp (
    .base_i   (disp_q),
    .take_i   (take),
    .tk_for_o (tk_for),
    .next_o   (disp_n)
  );

  assign serve_n = (|rel_ok) ? serve_q + W'(1) : serve_q;

  genvar gi;
  generate
    for (gi = 0; gi < N_REQ; gi++) begin : g_slot
      tlk_slot #(.W(W)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .take_i      (take[gi]),
        .new_tk_i    (tk_for[gi*W +: W]),
        .rel_i       (rel_i[gi]),
        .serve_nxt_i (serve_n),
        .active_o    (active[gi]),
        .ticket_o    (ticket_o[gi*W +: W]),
        .owner_o     (owner[gi]),
        .rel_ok_o    (rel_ok[gi]),
        .rel_bad_o   (rel_bad[gi])
      );
      // A repeat acquire while queued leaves the ticket alone.
      assert_dup_acquire_R7: assert property (@(posedge clk) disable iff (rst)
        active[gi] && acq_i[gi] && !rel_ok[gi] |=> $stable(ticket_o[gi*W +: W]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_q  <= '0;
      serve_q <= '0;
      err_q   <= 1'b0;
    end else begin
      disp_q  <= disp_n;
      serve_q <= serve_n;
      err_q   <= |rel_bad;
    end
  end

  assign granted_o = owner;
  assign rel_err_o = err_q;

  assert_single_owner_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner));
  assert_count_balance_R8: assert property (@(posedge clk) disable iff (rst)
    (disp_q - serve_q) == W'($countones(active)));
  assert_serve_step_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (serve_q == $past(serve_q)) || (serve_q == $past(serve_q) + W'(1)));
  assert_bad_release_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (|rel_bad) |=> rel_err_o);
  assert_bad_release_no_step_R6: assert property (@(posedge clk) disable iff (rst)
    (|rel_bad) && !(|rel_ok) |=> $stable(serve_q));
endmodule

// File: tb/ticket_lock_unit_bench.sv
module ticket_lock_unit_bench;
  localparam int N = 4;
  localparam int W = $clog2(N) + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   acq = '0;
  logic [N-1:0]   rel = '0;
  logic [N*W-1:0] ticket;
  logic [N-1:0]   granted;
  logic           rel_err;

  int n_checks = 0;
  int n_fail   = 0;

  bit           m_act [N];
  logic [W-1:0] m_tk  [N];
  logic [W-1:0] m_next, m_cur;
  logic         m_err;

  always #2.5 clk = ~clk;

  ticket_lock_unit #(.N_REQ(N)) u_ticket_lock_unit (
    .clk(clk), .rst(rst), .acq_i(acq), .rel_i(rel),
    .ticket_o(ticket), .granted_o(granted), .rel_err_o(rel_err)
  );

  function automatic logic [N-1:0] exp_grant();
    logic [N-1:0] g = '0;
    for (int i = 0; i < N; i++) g[i] = m_act[i] && (m_tk[i] == m_cur);
    return g;
  endfunction

  function automatic logic [N*W-1:0] exp_tickets();
    logic [N*W-1:0] t;
    for (int i = 0; i < N; i++) t[i*W +: W] = m_tk[i];
    return t;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_act[i] = 0; m_tk[i] = '0; end
    m_next = '0; m_cur = '0; m_err = 1'b0;
  endtask

  task automatic model_step(input logic [N-1:0] a, input logic [N-1:0] r);
    logic [N-1:0] g;
    bit pre_act [N];
    bit any_ok;
    g = exp_grant();
    any_ok = 0; m_err = 1'b0;
    for (int i = 0; i < N; i++) pre_act[i] = m_act[i];
    for (int i = 0; i < N; i++) begin
      if (r[i] && g[i]) begin any_ok = 1; m_act[i] = 0; end
      else if (r[i]) m_err = 1'b1;
    end
    if (any_ok) m_cur = m_cur + W'(1);
    for (int i = 0; i < N; i++) begin
      if (a[i] && !pre_act[i]) begin
        m_tk[i] = m_next; m_act[i] = 1; m_next = m_next + W'(1);
      end
    end
  endtask

  task automatic check_all(input string tag);
    n_checks += 3;
    if (granted !== exp_grant()) begin
      n_fail++;
      $display("FAIL %s granted: actual %b expected %b", tag, granted, exp_grant());
    end
    if (ticket !== exp_tickets()) begin
      n_fail++;
      $display("FAIL %s tickets: actual %h expected %h", tag, ticket, exp_tickets());
    end
    if (rel_err !== m_err) begin
      n_fail++;
      $display("FAIL %s rel_err: actual %b expected %b", tag, rel_err, m_err);
    end
  endtask

  task automatic cycle(input logic [N-1:0] a, input logic [N-1:0] r, input string tag);
    @(negedge clk);
    acq = a; rel = r;
    @(posedge clk);
    #1;
    model_step(a, r);
    check_all(tag);
    @(negedge clk);
    acq = '0; rel = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] a, r, g;
    int unsigned seed;
    seed = 32'd7;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_all("R1");

    cycle(4'b0001, 4'b0000, "R2");   // idx0 gets ticket 0, granted
    cycle(4'b1110, 4'b0000, "R3");   // idx1..3 get 1,2,3
    cycle(4'b0010, 4'b0000, "R7");   // idx1 already waiting: ignored
    cycle(4'b0000, 4'b0100, "R6");   // idx2 is not owner
    cycle(4'b0000, 4'b0000, "R6");   // flag lasts one cycle
    cycle(4'b0001, 4'b0001, "R5");   // owner releases, same-cycle acquire ignored
    cycle(4'b0001, 4'b0010, "R5");   // idx1 releases, idx0 requeues with ticket 4
    cycle(4'b0000, 4'b0100, "R4");
    cycle(4'b0000, 4'b1000, "R4");
    cycle(4'b1111, 4'b0001, "R8");   // tickets run past the wrap

    for (int k = 0; k < 3000; k++) begin
      g = exp_grant();
      a = '0; r = '0;
      for (int i = 0; i < N; i++) begin
        if (($urandom % 100) < 30) a[i] = 1'b1;
        if (g[i] && (($urandom % 100) < 45)) r[i] = 1'b1;
        if (!g[i] && (($urandom % 100) < 4)) r[i] = 1'b1;
      end
      cycle(a, r, "R8");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule